// File: doc/BRIEF.md
# Background Garbage Collection Controller

This block frees flash blocks that are filled with stale pages. When the allocator's count of free blocks drops below a programmable threshold, it scans every block and picks the one that holds the fewest live pages. Each live page is copied to a destination page obtained from the allocator. The emptied block is then erased, and the mapper is told where each moved page now lives. Finally the block is handed back to the allocator, or marked bad if the erase failed.

Copy and erase work goes out on a single command port. The command is held until a response comes back. Host traffic keeps priority: before each page copy the controller can give up one slot to a waiting host request. Collection continues block after block until the free count rises above the threshold plus a hysteresis margin.

Top module: `gc_ctrl`

## Requirements
- R1: From idle, collection starts when `free_cnt_i` is below `thresh_i`; while `free_cnt_i` is at or above `thresh_i` the controller stays idle (status 0).
- R2: The victim is the block with the fewest live pages among blocks that are neither free nor open; ties go to the lowest block index; a block whose pages are all live is never chosen, so no command is issued when no other block qualifies. Live bit of page p in block b is `valid_map_i[b*PPB+p]`.
- R3: Every live page of the victim is copied in ascending page order before the erase. Each copy first obtains one destination through the `dst_req_o`/`dst_ack_i` handshake, then issues `cmd_op_o`=0 with `cmd_src_o`={block,page} and `cmd_dst_o`= the granted page.
- R4: After the last copy, exactly one erase is issued, with `cmd_op_o`=1 and `cmd_src_o`={victim,0}.
- R5: After the erase response, the mapper receives one `map_upd_o` pulse for each moved page, in ascending page order, with `map_old_o`={victim,page} and `map_new_o`= the destination used for that page.
- R6: Before each copy, if `host_pend_i` is high, `host_slot_o` is raised for exactly one cycle with no command or request active. The copy then proceeds even if the host request is still pending.
- R7: After each released block, the controller returns to idle if `free_cnt_i` > `thresh_i`+`hyst_i`; otherwise it selects another victim.
- R8: An erase response with `rsp_ok_i`=0 gives a release with `rel_bad_o`=1 and no `done_o` pulse.
- R9: A release is a one-cycle `rel_valid_o` carrying the victim in `rel_blk_o`. `done_o` pulses in that cycle when the erase succeeded.
- R10: `status_o` reads 0 idle, 1 selecting, 2 copying (including yield and destination wait), 3 erasing, 4 remapping and releasing.
- R11: A command stays asserted with unchanged op and source until the cycle in which `rsp_valid_i` is seen.
- R12: After reset the controller is idle with every request, command, update and release output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_free_i | input | NB | Block is in the free pool |
| blk_open_i | input | NB | Block is currently being written |
| valid_map_i | input | NB*PPB | Live-page bitmap, bit b*PPB+p |
| free_cnt_i | input | CNT_W | Number of free blocks |
| thresh_i | input | CNT_W | Start threshold |
| hyst_i | input | CNT_W | Stop margin above the threshold |
| host_pend_i | input | 1 | Host request waiting for the port |
| host_slot_o | output | 1 | Slot given up to the host this cycle |
| dst_req_o | output | 1 | Request for a destination page |
| dst_ack_i | input | 1 | Destination page granted |
| dst_page_i | input | PA_W | Granted destination page |
| cmd_valid_o | output | 1 | Command active |
| cmd_op_o | output | 1 | 0 copy, 1 erase |
| cmd_src_o | output | PA_W | Source page {block,page} |
| cmd_dst_o | output | PA_W | Copy destination page |
| rsp_valid_i | input | 1 | Command response |
| rsp_ok_i | input | 1 | Response status, 0 means failure |
| map_upd_o | output | 1 | Mapping redirect valid |
| map_old_o | output | PA_W | Previous physical page |
| map_new_o | output | PA_W | New physical page |
| rel_valid_o | output | 1 | Block release |
| rel_blk_o | output | BLK_W | Released block |
| rel_bad_o | output | 1 | Released block is bad |
| status_o | output | 3 | Phase code |
| done_o | output | 1 | One block reclaimed |

## Verification
The hardest case to reach from the ports is a block that cannot be reclaimed mid-run: a failed erase leaves the free count unchanged, so the controller keeps hunting. The bench reaches it with a flash model that fails erases on a chosen block, then lowers the threshold to let the controller settle. The hysteresis stop needs several consecutive reclaims with fixed live-page counts. Victim order, tie-break and stop point are arranged so that the expected release sequence follows directly from the counts. An exhaustive sweep over all sixteen live patterns of one victim covers empty, full and partial blocks, with host pressure alternating between patterns.

// File: rtl/gc_pkg.sv
package gc_pkg;
    typedef enum logic [3:0] {
        G_IDLE, G_SCAN, G_PAGE, G_YIELD, G_DST, G_COPY, G_ERASE, G_REMAP, G_RELEASE
    } gc_st_e;

    localparam logic OP_COPY  = 1'b0;
    localparam logic OP_ERASE = 1'b1;

    localparam logic [2:0] STS_IDLE   = 3'd0;
    localparam logic [2:0] STS_SELECT = 3'd1;
    localparam logic [2:0] STS_COPY   = 3'd2;
    localparam logic [2:0] STS_ERASE  = 3'd3;
    localparam logic [2:0] STS_REMAP  = 3'd4;
endpackage

// File: rtl/gc_trigger.sv
module gc_trigger #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] free_cnt_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [CNT_W-1:0] hyst_i,
    output logic             low_o,
    output logic             high_o
);
    logic [CNT_W:0] stop_lvl;

    always_comb begin
        stop_lvl = {1'b0, thresh_i} + {1'b0, hyst_i};
        low_o    = free_cnt_i < thresh_i;
        high_o   = {1'b0, free_cnt_i} > stop_lvl;
    end
endmodule

// File: rtl/gc_victim_scan.sv
module gc_victim_scan #(
    parameter int NB  = 8,
    parameter int PPB = 4,
    localparam int BLK_W = $clog2(NB),
    localparam int VC_W  = $clog2(PPB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NB-1:0]     blk_free_i,
    input  logic [NB-1:0]     blk_open_i,
    input  logic [NB*PPB-1:0] valid_map_i,
    output logic              done_o,
    output logic              found_o,
    output logic [BLK_W-1:0]  blk_o
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             found;
        logic [BLK_W-1:0] idx;
        logic [BLK_W-1:0] best;
        logic [VC_W-1:0]  best_cnt;
    } scan_t;

    scan_t q, d;
    logic [PPB-1:0]  slice;
    logic [VC_W-1:0] live_cnt;
    logic            elig;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        slice    = valid_map_i[int'(q.idx)*PPB +: PPB];
        live_cnt = '0;
        for (int p = 0; p < PPB; p++) begin
            live_cnt = live_cnt + VC_W'(slice[p]);
        end
        elig = !blk_free_i[q.idx] && !blk_open_i[q.idx] && (live_cnt < VC_W'(PPB));
        if (start_i) begin
            d.busy     = 1'b1;
            d.found    = 1'b0;
            d.idx      = '0;
            d.best     = '0;
            d.best_cnt = VC_W'(PPB);
        end else if (q.busy) begin
            if (elig && (live_cnt < q.best_cnt)) begin
                d.found    = 1'b1;
                d.best     = q.idx;
                d.best_cnt = live_cnt;
            end
            if (q.idx == BLK_W'(NB - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.idx = q.idx + BLK_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o  = q.done;
    assign found_o = q.found;
    assign blk_o   = q.best;

    // R2
    pick_has_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.found) |-> (q.best_cnt < VC_W'(PPB)));
endmodule

// File: rtl/gc_move_log.sv
module gc_move_log #(
    parameter int PPB  = 4,
    parameter int PA_W = 5,
    localparam int PG_W = $clog2(PPB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            wr_i,
    input  logic [PG_W-1:0] wr_pg_i,
    input  logic [PA_W-1:0] wr_dst_i,
    input  logic [PG_W-1:0] rd_pg_i,
    output logic            moved_o,
    output logic [PA_W-1:0] dst_o
);
    typedef struct packed {
        logic [PPB-1:0]           moved;
        logic [PPB-1:0][PA_W-1:0] dst;
    } log_t;

    log_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.moved = '0;
        end else if (wr_i) begin
            d.moved[wr_pg_i] = 1'b1;
            d.dst[wr_pg_i]   = wr_dst_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign moved_o = q.moved[rd_pg_i];
    assign dst_o   = q.dst[rd_pg_i];

    // R3
    single_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |-> !q.moved[wr_pg_i]);
endmodule

// File: rtl/gc_ctrl.sv
module gc_ctrl
    import gc_pkg::*;
#(
    parameter int NB  = 8,
    parameter int PPB = 4,
    localparam int BLK_W = $clog2(NB),
    localparam int PG_W  = $clog2(PPB),
    localparam int PA_W  = BLK_W + PG_W,
    localparam int CNT_W = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     blk_free_i,
    input  logic [NB-1:0]     blk_open_i,
    input  logic [NB*PPB-1:0] valid_map_i,
    input  logic [CNT_W-1:0]  free_cnt_i,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic [CNT_W-1:0]  hyst_i,
    input  logic              host_pend_i,
    output logic              host_slot_o,
    output logic              dst_req_o,
    input  logic              dst_ack_i,
    input  logic [PA_W-1:0]   dst_page_i,
    output logic              cmd_valid_o,
    output logic              cmd_op_o,
    output logic [PA_W-1:0]   cmd_src_o,
    output logic [PA_W-1:0]   cmd_dst_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_ok_i,
    output logic              map_upd_o,
    output logic [PA_W-1:0]   map_old_o,
    output logic [PA_W-1:0]   map_new_o,
    output logic              rel_valid_o,
    output logic [BLK_W-1:0]  rel_blk_o,
    output logic              rel_bad_o,
    output logic [2:0]        status_o,
    output logic              done_o
);
    localparam int PGC_W = PG_W + 1;
    localparam logic [PGC_W-1:0] PG_END = PGC_W'(PPB);

    typedef struct packed {
        gc_st_e           st;
        logic             active;
        logic [BLK_W-1:0] victim;
        logic [PGC_W-1:0] pg;
        logic             yielded;
        logic [PA_W-1:0]  dst;
        logic             bad;
    } ctl_t;

    ctl_t q, d;

    logic             low, high;
    logic             scan_start, scan_done, scan_found;
    logic [BLK_W-1:0] scan_blk;
    logic             log_clr, log_wr, log_moved;
    logic [PA_W-1:0]  log_dst;
    logic [PG_W-1:0]  pg_lo;
    logic             page_live;

    assign pg_lo     = q.pg[PG_W-1:0];
    assign page_live = valid_map_i[int'(q.victim)*PPB + int'(pg_lo)];

    gc_trigger #(.CNT_W(CNT_W)) u_trig (
        .free_cnt_i (free_cnt_i),
        .thresh_i   (thresh_i),
        .hyst_i     (hyst_i),
        .low_o      (low),
        .high_o     (high)
    );

    gc_victim_scan #(.NB(NB), .PPB(PPB)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (scan_start),
        .blk_free_i  (blk_free_i),
        .blk_open_i  (blk_open_i),
        .valid_map_i (valid_map_i),
        .done_o      (scan_done),
        .found_o     (scan_found),
        .blk_o       (scan_blk)
    );

    gc_move_log #(.PPB(PPB), .PA_W(PA_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (log_clr),
        .wr_i     (log_wr),
        .wr_pg_i  (pg_lo),
        .wr_dst_i (q.dst),
        .rd_pg_i  (pg_lo),
        .moved_o  (log_moved),
        .dst_o    (log_dst)
    );

    always_comb begin
        d          = q;
        scan_start = 1'b0;
        log_clr    = 1'b0;
        log_wr     = 1'b0;
        unique case (q.st)
            G_IDLE: begin
                if (q.active && high) begin
                    d.active = 1'b0;
                end else if (q.active || low) begin
                    d.active   = 1'b1;
                    d.st       = G_SCAN;
                    scan_start = 1'b1;
                end
            end
            G_SCAN: begin
                if (scan_done) begin
                    if (scan_found) begin
                        d.victim  = scan_blk;
                        d.pg      = '0;
                        d.yielded = 1'b0;
                        d.bad     = 1'b0;
                        log_clr   = 1'b1;
                        d.st      = G_PAGE;
                    end else begin
                        d.st = G_IDLE;
                    end
                end
            end
            G_PAGE: begin
                if (q.pg == PG_END) begin
                    d.st = G_ERASE;
                end else if (page_live) begin
                    d.st = (host_pend_i && !q.yielded) ? G_YIELD : G_DST;
                end else begin
                    d.pg = q.pg + PGC_W'(1);
                end
            end
            G_YIELD: begin
                d.yielded = 1'b1;
                d.st      = G_PAGE;
            end
            G_DST: begin
                if (dst_ack_i) begin
                    d.dst = dst_page_i;
                    d.st  = G_COPY;
                end
            end
            G_COPY: begin
                if (rsp_valid_i) begin
                    log_wr    = 1'b1;
                    d.pg      = q.pg + PGC_W'(1);
                    d.yielded = 1'b0;
                    d.st      = G_PAGE;
                end
            end
            G_ERASE: begin
                if (rsp_valid_i) begin
                    d.bad = !rsp_ok_i;
                    d.pg  = '0;
                    d.st  = G_REMAP;
                end
            end
            G_REMAP: begin
                if (q.pg == PG_END) begin
                    d.st = G_RELEASE;
                end else begin
                    d.pg = q.pg + PGC_W'(1);
                end
            end
            G_RELEASE: begin
                d.st = G_IDLE;
            end
            default: d.st = G_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= G_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        host_slot_o = (q.st == G_YIELD);
        dst_req_o   = (q.st == G_DST);
        cmd_valid_o = (q.st == G_COPY) || (q.st == G_ERASE);
        cmd_op_o    = (q.st == G_ERASE) ? OP_ERASE : OP_COPY;
        cmd_src_o   = (q.st == G_ERASE) ? {q.victim, {PG_W{1'b0}}} : {q.victim, pg_lo};
        cmd_dst_o   = q.dst;
        map_upd_o   = (q.st == G_REMAP) && (q.pg != PG_END) && log_moved;
        map_old_o   = {q.victim, pg_lo};
        map_new_o   = log_dst;
        rel_valid_o = (q.st == G_RELEASE);
        rel_blk_o   = q.victim;
        rel_bad_o   = q.bad;
        done_o      = (q.st == G_RELEASE) && !q.bad;
        case (q.st)
            G_IDLE:                        status_o = STS_IDLE;
            G_SCAN:                        status_o = STS_SELECT;
            G_PAGE, G_YIELD, G_DST, G_COPY: status_o = STS_COPY;
            G_ERASE:                       status_o = STS_ERASE;
            default:                       status_o = STS_REMAP;
        endcase
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !rsp_valid_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_src_o)));

    // R6
    slot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_slot_o |=> !host_slot_o);

    // R4
    erase_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_ERASE) |-> (q.pg == PG_END));

    // R1
    scan_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == G_SCAN && $past(q.st) == G_IDLE) |-> $past(q.active || low));
endmodule

// File: tb/gc_ctrl_bench.sv
`timescale 1ns/1ps
module gc_ctrl_bench;
    localparam int NB = 8;
    localparam int PPB = 4;
    localparam int PA_W = 5;
    localparam int LOGN = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NB-1:0] blk_free, blk_open;
    logic [NB*PPB-1:0] valid_map;
    logic [3:0] free_cnt, thresh, hyst;
    logic host_pend, host_slot, dst_req, dst_ack;
    logic [PA_W-1:0] dst_page, cmd_src, cmd_dst, map_old, map_new;
    logic cmd_valid, cmd_op, rsp_valid, rsp_ok, map_upd, rel_valid, rel_bad, done;
    logic [2:0] rel_blk, status;

    logic cfg_load;
    logic [NB-1:0] cfg_free, cfg_open;
    logic [NB*PPB-1:0] cfg_valid;
    logic [3:0] fail_blk;
    logic [1:0] wp;
    int lat;

    gc_ctrl u_gc_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_free_i(blk_free), .blk_open_i(blk_open),
        .valid_map_i(valid_map), .free_cnt_i(free_cnt), .thresh_i(thresh), .hyst_i(hyst),
        .host_pend_i(host_pend), .host_slot_o(host_slot), .dst_req_o(dst_req),
        .dst_ack_i(dst_ack), .dst_page_i(dst_page), .cmd_valid_o(cmd_valid),
        .cmd_op_o(cmd_op), .cmd_src_o(cmd_src), .cmd_dst_o(cmd_dst),
        .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok), .map_upd_o(map_upd),
        .map_old_o(map_old), .map_new_o(map_new), .rel_valid_o(rel_valid),
        .rel_blk_o(rel_blk), .rel_bad_o(rel_bad), .status_o(status), .done_o(done)
    );

    always_comb begin
        free_cnt = '0;
        for (int b = 0; b < NB; b++) free_cnt = free_cnt + 4'(blk_free[b]);
    end

    // flash, allocator and pool model; destination block is always block 5
    always @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_ok <= 1'b0; lat <= 0; dst_ack <= 1'b0; wp <= '0;
            dst_page <= '0;
        end else if (cfg_load) begin
            valid_map <= cfg_valid; blk_free <= cfg_free; blk_open <= cfg_open;
        end else begin
            dst_ack <= dst_req && !dst_ack;
            if (dst_req && !dst_ack) begin
                dst_page <= {3'd5, wp};
                wp <= wp + 2'd1;
            end
            if (rsp_valid) begin
                rsp_valid <= 1'b0;
            end else if (cmd_valid) begin
                if (lat == 1) begin
                    lat <= 0;
                    rsp_valid <= 1'b1;
                    if (cmd_op) begin
                        rsp_ok <= ({1'b0, cmd_src[4:2]} != fail_blk);
                        if ({1'b0, cmd_src[4:2]} != fail_blk)
                            valid_map[int'(cmd_src[4:2])*PPB +: PPB] <= '0;
                    end else begin
                        rsp_ok <= 1'b1;
                        valid_map[cmd_dst] <= 1'b1;
                    end
                end else begin
                    lat <= lat + 1;
                end
            end
            if (rel_valid && !rel_bad) blk_free[rel_blk] <= 1'b1;
        end
    end

    // monitor
    int n_cmd = 0, n_map = 0, n_rel = 0, n_slot = 0, n_done = 0, n_busy = 0;
    int st_err = 0, hold_err = 0;
    logic c_op_l [LOGN];
    logic [PA_W-1:0] c_src_l [LOGN], c_dst_l [LOGN], m_old_l [LOGN], m_new_l [LOGN];
    logic [2:0] r_blk_l [LOGN];
    logic r_bad_l [LOGN];
    logic p_wait = 1'b0, p_op = 1'b0;
    logic [PA_W-1:0] p_src = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_wait && (!cmd_valid || cmd_op != p_op || cmd_src != p_src)) hold_err++;
            p_wait = cmd_valid && !rsp_valid; p_op = cmd_op; p_src = cmd_src;
            if (cmd_valid && rsp_valid) begin
                c_op_l[n_cmd % LOGN] = cmd_op; c_src_l[n_cmd % LOGN] = cmd_src;
                c_dst_l[n_cmd % LOGN] = cmd_dst; n_cmd++;
            end
            if (map_upd) begin
                m_old_l[n_map % LOGN] = map_old; m_new_l[n_map % LOGN] = map_new; n_map++;
            end
            if (rel_valid) begin
                r_blk_l[n_rel % LOGN] = rel_blk; r_bad_l[n_rel % LOGN] = rel_bad; n_rel++;
            end
            if (host_slot) n_slot++;
            if (done) n_done++;
            if (status != 3'd0) n_busy++;
            if (cmd_valid && !cmd_op && status != 3'd2) st_err++;
            if (cmd_valid && cmd_op && status != 3'd3) st_err++;
            if ((map_upd || rel_valid) && status != 3'd4) st_err++;
            if ((host_slot || dst_req) && status != 3'd2) st_err++;
        end else begin
            p_wait = 1'b0;
        end
    end

    int compared = 0, mismatched = 0;
    int b_cmd, b_map, b_rel, b_slot, b_done, b_busy;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_test(input logic [NB*PPB-1:0] v, input logic [NB-1:0] fr,
                              input logic [NB-1:0] op, input int th, input int hy,
                              input int fb, input bit hp);
        @(negedge clk);
        rst_n = 1'b0; thresh = '0; hyst = '0; host_pend = 1'b0; cfg_load = 1'b0;
        fail_blk = 4'(fb);
        repeat (2) @(negedge clk);
        cfg_valid = v; cfg_free = fr; cfg_open = op;
        rst_n = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        b_cmd = n_cmd; b_map = n_map; b_rel = n_rel; b_slot = n_slot; b_done = n_done;
        b_busy = n_busy;
        thresh = 4'(th); hyst = 4'(hy); host_pend = hp;
    endtask

    task automatic wait_rel(input int n);
        for (int i = 0; i < 800; i++) begin
            @(posedge clk);
            if (n_rel - b_rel >= n) break;
        end
        @(negedge clk);
    endtask

    initial begin
        thresh = '0; hyst = '0; host_pend = 1'b0; cfg_load = 1'b0; fail_blk = 4'd15;
        cfg_valid = '0; cfg_free = '0; cfg_open = '0;
        blk_free = '0; blk_open = '0; valid_map = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(status == 3'd0, "R12 status", status, 0);
        chk({host_slot, dst_req, cmd_valid, map_upd, rel_valid, done} == 6'd0,
            "R12 outputs", {host_slot, dst_req, cmd_valid, map_upd, rel_valid, done}, 0);

        // R1: free count equal to threshold keeps idle, one below starts
        start_test({4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h1}, 8'hC0, 8'h20, 2, 0, 15, 0);
        repeat (40) @(negedge clk);
        chk(n_busy - b_busy == 0, "R1 idle at threshold", n_busy - b_busy, 0);
        thresh = 4'd3;
        repeat (3) @(negedge clk);
        chk(n_busy - b_busy > 0, "R1 start below threshold", n_busy - b_busy, 1);
        thresh = 4'd0;
        repeat (120) @(negedge clk);
        chk(status == 3'd0, "R7 settles idle", status, 0);

        // exhaustive sweep of victim live patterns in block 0
        for (int p = 0; p < 16; p++) begin
            automatic bit hp = p[0];
            automatic int nl = 0;
            automatic int k = 0;
            start_test({4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'(p)}, 8'h80, 8'h20, 2, 0, 15, hp);
            for (int pg = 0; pg < PPB; pg++) nl += p[pg];
            if (p == 15) begin
                repeat (150) @(negedge clk);
                chk(n_cmd - b_cmd == 0, "R2 full block never chosen", n_cmd - b_cmd, 0);
                chk(n_rel - b_rel == 0, "R2 no release", n_rel - b_rel, 0);
            end else begin
                wait_rel(1);
                thresh = 4'd0;
                repeat (30) @(negedge clk);
                chk(n_cmd - b_cmd == nl + 1, "R3 command count", n_cmd - b_cmd, nl + 1);
                for (int pg = 0; pg < PPB; pg++) begin
                    if (p[pg]) begin
                        automatic int ix = (b_cmd + k) % LOGN;
                        automatic int mx = (b_map + k) % LOGN;
                        chk(c_op_l[ix] == 1'b0, "R3 copy op", c_op_l[ix], 0);
                        chk(c_src_l[ix] == 5'(pg), "R3 copy src", c_src_l[ix], pg);
                        chk(c_dst_l[ix] == 5'(20 + k), "R3 copy dst", c_dst_l[ix], 20 + k);
                        chk(m_old_l[mx] == 5'(pg), "R5 remap old", m_old_l[mx], pg);
                        chk(m_new_l[mx] == 5'(20 + k), "R5 remap new", m_new_l[mx], 20 + k);
                        k++;
                    end
                end
                chk(c_op_l[(b_cmd + nl) % LOGN] == 1'b1, "R4 erase op", c_op_l[(b_cmd + nl) % LOGN], 1);
                chk(c_src_l[(b_cmd + nl) % LOGN] == 5'd0, "R4 erase src", c_src_l[(b_cmd + nl) % LOGN], 0);
                chk(n_map - b_map == nl, "R5 remap count", n_map - b_map, nl);
                chk(n_rel - b_rel == 1, "R9 release count", n_rel - b_rel, 1);
                chk(r_blk_l[b_rel % LOGN] == 3'd0 && !r_bad_l[b_rel % LOGN], "R9 release blk",
                    r_blk_l[b_rel % LOGN], 0);
                chk(n_done - b_done == 1, "R9 done pulse", n_done - b_done, 1);
                chk(n_slot - b_slot == (hp ? nl : 0), "R6 yield slots", n_slot - b_slot, hp ? nl : 0);
            end
            thresh = 4'd0;
            repeat (30) @(negedge clk);
            chk(status == 3'd0, "R10 idle code", status, 0);
        end

        // R7 hysteresis and R2 fewest-live with tie to lowest index
        start_test({4'h0, 4'hF, 4'h0, 4'hF, 4'h7, 4'h8, 4'h4, 4'h3}, 8'h80, 8'h20, 2, 1, 15, 1);
        wait_rel(3);
        repeat (200) @(negedge clk);
        chk(n_rel - b_rel == 3, "R7 stop after margin", n_rel - b_rel, 3);
        chk(r_blk_l[b_rel % LOGN] == 3'd1, "R2 fewest first", r_blk_l[b_rel % LOGN], 1);
        chk(r_blk_l[(b_rel + 1) % LOGN] == 3'd2, "R2 tie order", r_blk_l[(b_rel + 1) % LOGN], 2);
        chk(r_blk_l[(b_rel + 2) % LOGN] == 3'd0, "R2 third pick", r_blk_l[(b_rel + 2) % LOGN], 0);
        chk(n_cmd - b_cmd == 7, "R3 copies and erases", n_cmd - b_cmd, 7);
        chk(n_slot - b_slot == 4, "R6 slot per copy", n_slot - b_slot, 4);
        chk(status == 3'd0, "R7 idle after stop", status, 0);

        // R8 failed erase
        start_test({4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h5}, 8'h80, 8'h20, 2, 0, 0, 0);
        wait_rel(1);
        thresh = 4'd0;
        chk(n_rel - b_rel >= 1 && r_bad_l[b_rel % LOGN], "R8 bad flag", r_bad_l[b_rel % LOGN], 1);
        chk(n_done - b_done == 0, "R8 no done", n_done - b_done, 0);
        repeat (150) @(negedge clk);
        chk(status == 3'd0, "R8 settles", status, 0);

        chk(st_err == 0, "R10 status codes", st_err, 0);
        chk(hold_err == 0, "R11 command hold", hold_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule